// File: doc/BRIEF.md
# Indexed Battery-Backed RAM Access Controller

This block lets a host reach two battery-backed byte memories through a narrow I/O window. Each memory, a standard bank and an extended bank, has an address pair on the host bus: the lower address holds an index pointer and the next address moves data to or from the location that pointer selects. Both base addresses are inputs, so system configuration logic can place the windows anywhere. The usual placement is 0x70/0x71 for the standard bank and 0x72/0x73 for the extended bank.

In the standard bank, indexes 0x00 to 0x0D are not plain memory. They reach a small set of timekeeping and control registers, here reduced to plain storage. Three further indexes can be redirected to override registers when an enable is set. Those indexes come from inputs and are searched in a fixed priority. Every remaining standard index and all 128 extended indexes are general-purpose bytes. Lock inputs, a battery-valid bit and a main-power status input gate each access, so that protected or unpowered accesses leave the stored data unchanged and reads return all ones.

Top module: `bbram_ctl`

## Requirements
- R1: A host write at a bank's base address loads bits 6:0 of the data into that bank's index pointer, and bit 7 is dropped. A read at the base address returns {0, pointer}. Data accesses never change the pointer, so there is no auto-increment.
- R2: A read strobe sampled on a rising edge updates `rdata` at that edge. `rdata` holds its value in every cycle with no read strobe.
- R3: A data write at base+1 stores a byte at the selected general-purpose index, and a later data read there returns it. The standard and extended banks are separate storage, so equal indexes do not alias.
- R4: Standard indexes 0x00 to 0x0C are writable registers that are separate from RAM. Index 0x0D reads as {battery-valid, 7'b0} and ignores writes.
- R5: When override is enabled, a standard index that equals override index 0, 1 or 2 reaches override register 0, 1 or 2, and this takes precedence over the fixed registers and RAM. The comparison order is 0, then 1, then 2, so duplicates resolve to the lowest number. When override is disabled, the same index reaches its normal location.
- R6: While a bank's lock input is 1, its data writes change nothing and its data reads return 0xFF. Its index register stays accessible.
- R7: While battery-valid is 0, writes to the fixed registers and the override registers are ignored. General-purpose RAM writes still take effect.
- R8: While main power is not good (`main_pwr_ok`=0), every write is ignored, including index writes, and every read returns 0xFF.
- R9: A read at an address that matches none of the four window addresses returns 0xFF, and a write there changes nothing. When window addresses coincide, the priority order is standard index, then standard data, then extended index, then extended data.
- R10: After reset, `rdata` is 0xFF, both index pointers are 0, and the fixed and override registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 8 | Host I/O address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| std_base | input | 8 | Standard bank index address; data is at +1 |
| ext_base | input | 8 | Extended bank index address; data is at +1 |
| std_lock | input | 1 | Lock for standard bank data accesses |
| ext_lock | input | 1 | Lock for extended bank data accesses |
| vrt | input | 1 | Battery-valid bit |
| main_pwr_ok | input | 1 | Main supply within operating range |
| ovr_en | input | 1 | Enable for the programmable-index overrides |
| ovr_idx0 | input | 7 | Override 0 index (highest priority) |
| ovr_idx1 | input | 7 | Override 1 index |
| ovr_idx2 | input | 7 | Override 2 index (lowest priority) |

## Verification
A fill pass writes distinct patterns to every index of both banks. The fixed registers, RAM and the extended bank therefore hold different values at the same index, and any aliasing or misrouting shows up as a wrong byte. Directed cases separate the override paths: duplicated override indexes, overrides placed on a fixed register, and overrides turned on and off at one index. They also toggle lock, battery-valid and power one at a time, to show which gate blocks which target. Coinciding window addresses and moved bases test the decode priority. A long random mix of index writes, data writes, reads, unmapped addresses and gate changes is then compared against a bench model of the same rules.

// File: rtl/bbram_ctl.sv
module bbram_ctl #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int IW   = 7,
  parameter int NFIX = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] std_base,
  input  logic [AW-1:0] ext_base,
  input  logic          std_lock,
  input  logic          ext_lock,
  input  logic          vrt,
  input  logic          main_pwr_ok,
  input  logic          ovr_en,
  input  logic [IW-1:0] ovr_idx0,
  input  logic [IW-1:0] ovr_idx1,
  input  logic [IW-1:0] ovr_idx2
);
  localparam int DEPTH = 1 << IW;
  localparam int FW    = $clog2(NFIX);
  localparam logic [DW-1:0] NODATA = '1;
  localparam logic [IW-1:0] RO_IDX = IW'(NFIX - 1);

  logic [IW-1:0] sidx, xidx;
  logic [DW-1:0] sram [DEPTH];
  logic [DW-1:0] xram [DEPTH];
  logic [DW-1:0] fixr [NFIX];
  logic [DW-1:0] ovr_r [3];

  logic [AW-1:0] std_dat_a, ext_dat_a;
  assign std_dat_a = std_base + AW'(1);
  assign ext_dat_a = ext_base + AW'(1);

  logic hit_si, hit_sd, hit_xi, hit_xd;
  assign hit_si = (addr == std_base);
  assign hit_sd = !hit_si && (addr == std_dat_a);
  assign hit_xi = !hit_si && !hit_sd && (addr == ext_base);
  assign hit_xd = !hit_si && !hit_sd && !hit_xi && (addr == ext_dat_a);

  logic [2:0] om;
  assign om[0] = ovr_en && (sidx == ovr_idx0);
  assign om[1] = ovr_en && !om[0] && (sidx == ovr_idx1);
  assign om[2] = ovr_en && !om[0] && !om[1] && (sidx == ovr_idx2);

  logic is_fix, is_ro, is_sram;
  assign is_fix  = (om == 3'b000) && (sidx < IW'(NFIX));
  assign is_ro   = is_fix && (sidx == RO_IDX);
  assign is_sram = (om == 3'b000) && !is_fix;

  logic [FW-1:0] fsel;
  assign fsel = sidx[FW-1:0];

  logic sd_ok, xd_ok;
  assign sd_ok = wr && main_pwr_ok && hit_sd && !std_lock;
  assign xd_ok = wr && main_pwr_ok && hit_xd && !ext_lock;

  logic we_fix;
  logic [2:0] we_ovr;
  assign we_fix = sd_ok && is_fix && !is_ro && vrt;
  assign we_ovr = (sd_ok && vrt) ? om : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sidx <= '0;
      xidx <= '0;
      for (int i = 0; i < NFIX; i++) fixr[i] <= '0;
      for (int k = 0; k < 3; k++) ovr_r[k] <= '0;
    end else begin
      if (wr && main_pwr_ok && hit_si) sidx <= wdata[IW-1:0];
      if (wr && main_pwr_ok && hit_xi) xidx <= wdata[IW-1:0];
      if (we_fix) fixr[fsel] <= wdata;
      for (int k = 0; k < 3; k++)
        if (we_ovr[k]) ovr_r[k] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (sd_ok && is_sram) sram[sidx] <= wdata;
    if (xd_ok) xram[xidx] <= wdata;
  end

  logic [DW-1:0] std_val, rnext;
  always_comb begin
    if (om[0])       std_val = ovr_r[0];
    else if (om[1])  std_val = ovr_r[1];
    else if (om[2])  std_val = ovr_r[2];
    else if (is_ro)  std_val = {vrt, {(DW-1){1'b0}}};
    else if (is_fix) std_val = fixr[fsel];
    else             std_val = sram[sidx];
  end

  always_comb begin
    if (!main_pwr_ok) rnext = NODATA;
    else if (hit_si)  rnext = {{(DW-IW){1'b0}}, sidx};
    else if (hit_sd)  rnext = std_lock ? NODATA : std_val;
    else if (hit_xi)  rnext = {{(DW-IW){1'b0}}, xidx};
    else if (hit_xd)  rnext = ext_lock ? NODATA : xram[xidx];
    else              rnext = NODATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= NODATA;
    else if (rd) rdata <= rnext;
  end
endmodule

// File: rtl/bbram_ctl_chk.sv
module bbram_ctl_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic          wr,
  input logic [DW-1:0] rdata,
  input logic [AW-1:0] std_base,
  input logic [AW-1:0] ext_base,
  input logic          std_lock,
  input logic          ext_lock,
  input logic          main_pwr_ok,
  input logic [IW-1:0] sidx,
  input logic [IW-1:0] xidx
);
  logic [AW-1:0] sd_a, xd_a;
  assign sd_a = std_base + AW'(1);
  assign xd_a = ext_base + AW'(1);

  logic mapped;
  assign mapped = (addr == std_base) || (addr == sd_a) || (addr == ext_base) || (addr == xd_a);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  p_nopwr_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !main_pwr_ok |=> rdata == '1);

  p_nopwr_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !main_pwr_ok |=> $stable(sidx) && $stable(xidx));

  p_idx_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd && main_pwr_ok && addr == std_base |=> rdata[DW-1] == 1'b0);

  p_no_autoinc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd || wr) && addr == sd_a && addr != std_base |=> $stable(sidx));

  p_slock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd && std_lock && addr == sd_a && addr != std_base |=> rdata == '1);

  p_xlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd && ext_lock && addr == xd_a && addr != std_base && addr != sd_a && addr != ext_base
    |=> rdata == '1);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !mapped |=> rdata == '1);
endmodule

bind bbram_ctl bbram_ctl_chk #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .rdata(rdata),
  .std_base(std_base), .ext_base(ext_base), .std_lock(std_lock), .ext_lock(ext_lock),
  .main_pwr_ok(main_pwr_ok), .sidx(sidx), .xidx(xidx)
);

// File: tb/sim_bbram_ctl.sv
`timescale 1ns/1ps
module sim_bbram_ctl;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, std_base = 8'h70, ext_base = 8'h72;
  logic rd = 0, wr = 0, std_lock = 0, ext_lock = 0, vrt = 1, pwr = 1, ovr_en = 0;
  logic [6:0] o0 = 7'h20, o1 = 7'h21, o2 = 7'h22;
  wire  [7:0] rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bbram_ctl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
    .std_base(std_base), .ext_base(ext_base), .std_lock(std_lock), .ext_lock(ext_lock),
    .vrt(vrt), .main_pwr_ok(pwr), .ovr_en(ovr_en),
    .ovr_idx0(o0), .ovr_idx1(o1), .ovr_idx2(o2)
  );

  logic [7:0] m_s [128];
  logic [7:0] m_x [128];
  logic [7:0] m_f [14];
  logic [7:0] m_o [3];
  logic [6:0] m_si = 0, m_xi = 0;

  // 0..2 override, 10 fixed, 11 read-only control, 12 RAM
  function automatic int route();
    if (ovr_en && m_si == o0) return 0;
    if (ovr_en && m_si == o1) return 1;
    if (ovr_en && m_si == o2) return 2;
    if (m_si == 7'h0D) return 11;
    if (m_si < 7'h0E) return 10;
    return 12;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    int r;
    if (!pwr) return 8'hFF;
    if (a == std_base) return {1'b0, m_si};
    if (a == std_base + 8'd1) begin
      if (std_lock) return 8'hFF;
      r = route();
      if (r < 3) return m_o[r];
      if (r == 11) return {vrt, 7'h0};
      if (r == 10) return m_f[m_si];
      return m_s[m_si];
    end
    if (a == ext_base) return {1'b0, m_xi};
    if (a == ext_base + 8'd1) return ext_lock ? 8'hFF : m_x[m_xi];
    return 8'hFF;
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    int r;
    if (!pwr) return;
    if (a == std_base) m_si = d[6:0];
    else if (a == std_base + 8'd1) begin
      if (std_lock) return;
      r = route();
      if (r < 3) begin if (vrt) m_o[r] = d; end
      else if (r == 10) begin if (vrt) m_f[m_si] = d; end
      else if (r == 12) m_s[m_si] = d;
    end
    else if (a == ext_base) m_xi = d[6:0];
    else if (a == ext_base + 8'd1) begin
      if (!ext_lock) m_x[m_xi] = d;
    end
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    model_wr(a, d);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd = 1;
    e = exp_rd(a);
    @(negedge clk);
    rd = 0;
    check(rdata, e, tag);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd4242));
    for (int i = 0; i < 14; i++) m_f[i] = 0;
    for (int k = 0; k < 3; k++) m_o[k] = 0;
    repeat (3) @(negedge clk);
    check(rdata, 8'hFF, "R10 rdata at reset");
    rst_n = 1;
    do_rd(8'h70, "R10 std index at reset");
    do_rd(8'h72, "R10 ext index at reset");
    do_wr(8'h70, 8'h03);
    do_rd(8'h71, "R10 fixed reg at reset");

    for (int i = 0; i < 128; i++) begin
      do_wr(8'h70, 8'(i));
      do_wr(8'h71, 8'(i) ^ 8'h5A);
      do_wr(8'h72, 8'(i));
      do_wr(8'h73, ~8'(i));
    end

    do_wr(8'h70, 8'hC5);
    do_rd(8'h70, "R1 index bit7 dropped");
    do_rd(8'h71, "R1 first data read");
    do_rd(8'h71, "R1 second data read same location");
    do_rd(8'h70, "R1 index kept after data access");
    held = rdata;
    @(negedge clk);
    check(rdata, held, "R2 rdata held without strobe");

    do_wr(8'h70, 8'h40); do_wr(8'h72, 8'h40);
    do_rd(8'h71, "R3 std RAM readback");
    do_rd(8'h73, "R3 ext RAM distinct at same index");
    do_wr(8'h71, 8'hE1);
    do_rd(8'h71, "R3 std RAM overwrite");
    do_rd(8'h73, "R3 ext unaffected by std write");

    do_wr(8'h70, 8'h0D);
    do_rd(8'h71, "R4 control D shows battery-valid");
    do_wr(8'h71, 8'h33);
    do_rd(8'h71, "R4 control D ignores writes");
    do_wr(8'h70, 8'h05);
    do_rd(8'h71, "R4 fixed reg readback");

    ovr_en = 1; o0 = 7'h30; o1 = 7'h30; o2 = 7'h02;
    do_wr(8'h70, 8'h30); do_wr(8'h71, 8'hC3);
    do_rd(8'h71, "R5 override 0 wins duplicate");
    o0 = 7'h50;
    do_rd(8'h71, "R5 override 1 after 0 moved");
    ovr_en = 0;
    do_rd(8'h71, "R5 disabled reaches RAM");
    ovr_en = 1;
    do_wr(8'h70, 8'h02); do_wr(8'h71, 8'h9E);
    do_rd(8'h71, "R5 override 2 over fixed reg");
    ovr_en = 0;
    do_rd(8'h71, "R5 fixed reg untouched by override write");

    std_lock = 1;
    do_wr(8'h70, 8'h41); do_wr(8'h71, 8'h77);
    do_rd(8'h71, "R6 locked read");
    do_rd(8'h70, "R6 index accessible when locked");
    std_lock = 0;
    do_rd(8'h71, "R6 locked write had no effect");
    ext_lock = 1;
    do_wr(8'h73, 8'h11);
    do_rd(8'h73, "R6 ext locked read");
    ext_lock = 0;
    do_rd(8'h73, "R6 ext locked write had no effect");

    vrt = 0;
    do_wr(8'h70, 8'h04); do_wr(8'h71, 8'hAB);
    do_rd(8'h71, "R7 fixed write blocked");
    do_wr(8'h70, 8'h0D);
    do_rd(8'h71, "R7 control D shows invalid");
    do_wr(8'h70, 8'h60); do_wr(8'h71, 8'hBC);
    do_rd(8'h71, "R7 RAM write allowed");
    vrt = 1;

    pwr = 0;
    do_rd(8'h70, "R8 index read blocked");
    do_wr(8'h70, 8'h10); do_wr(8'h71, 8'h00); do_wr(8'h73, 8'h00);
    pwr = 1;
    do_rd(8'h70, "R8 index write blocked");
    do_rd(8'h71, "R8 data write blocked");
    do_rd(8'h73, "R8 ext data write blocked");

    do_rd(8'h10, "R9 unmapped read");
    do_wr(8'h74, 8'h12);
    do_rd(8'h71, "R9 unmapped write no effect");
    std_base = 8'h20; ext_base = 8'h21;
    do_rd(8'h70, "R9 old base now unmapped");
    do_wr(8'h21, 8'h66);
    do_rd(8'h21, "R9 std data beats ext index");
    do_rd(8'h22, "R9 ext data at moved base");
    std_base = 8'h70; ext_base = 8'h72;

    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom_range(0, 19));
      case ($urandom_range(0, 4))
        0: a = 8'h70; 1: a = 8'h71; 2: a = 8'h72; 3: a = 8'h73;
        default: a = 8'($urandom_range(0, 255));
      endcase
      if (op == 0) std_lock = ~std_lock;
      else if (op == 1) ext_lock = ~ext_lock;
      else if (op == 2) vrt = ~vrt;
      else if (op == 3) pwr = ($urandom_range(0, 3) != 0);
      else if (op == 4) begin
        ovr_en = ~ovr_en;
        o0 = 7'($urandom_range(0, 15)); o1 = 7'($urandom_range(0, 15)); o2 = 7'($urandom_range(0, 15));
      end
      else if (op < 12) do_wr(a, ((a == 8'h70) ? 8'($urandom_range(0, 15)) : 8'($urandom_range(0, 255))));
      else do_rd(a, "R2 random mix");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule